// File: doc/BRIEF.md
# Gated Decade Frequency Counter

This block measures how fast an asynchronous pulse train runs. It opens a counting window of fixed length, derived from the reference clock, and counts rising edges of the input inside that window. A divide-by-two stage comes first, and a chain of BCD decade counters follows it. When the window closes, the decade contents are copied into output holding registers that drive a numeric readout. The counters are then cleared, and the next window starts from zero.

Each measurement cycle has three phases: the counting window of `GATE_CYCLES` clock cycles, one strobe cycle that loads the holding registers, and one clear cycle that empties the counters. A new result therefore appears every `GATE_CYCLES + 2` clock cycles, and a one-cycle valid pulse marks it. If the count runs past the largest value the decades can hold, the digits wrap and an overflow flag is reported with that result.

Top module: `freq_counter_top`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `digits_o` is all zero and `ovf_o` and `valid_o` are low.
- R2: A published result equals floor(E/2), where E is the number of input rising edges counted in the window. It is encoded as BCD with digit k (k=0 least significant) at bits [4k+3:4k] of `digits_o`.
- R3: Every decade holds only the values 0 to 9. Going from 9 to 0 carries one unit into the next decade.
- R4: The counting window lasts `GATE_CYCLES` clock cycles. Successive `valid_o` pulses are exactly `GATE_CYCLES + 2` cycles apart, and the counters do not move outside the window.
- R5: `valid_o` is high for exactly one cycle, in the cycle in which the new result first appears on `digits_o` and `ovf_o`.
- R6: Between two `valid_o` pulses, `digits_o` and `ovf_o` hold their value, even while input edges are being counted.
- R7: The decades, the divide-by-two stage and the overflow flag are cleared before each window. A window with no edges reads zero whatever came before, and an odd leftover edge is not carried into the next window.
- R8: When the count passes 10^NUM_DIGITS - 1, the digits wrap modulo 10^NUM_DIGITS and `ovf_o` is high with that result. The next result that does not overflow reports `ovf_o` low.
- R9: The input passes through a synchronizer of `SYNC_STAGES` flops. A high level that is held for many cycles is counted as a single rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_i | input | 1 | Asynchronous pulse train to be measured |
| digits_o | output | 4*NUM_DIGITS | Latched BCD result, least significant digit in the low bits |
| ovf_o | output | 1 | Overflow flag for the latched result |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench builds two instances. The first has four digits and a 5200-cycle window, so a single window can hold up to about 2590 input edges. That drives carries through all four decades and lets the cycle spacing between results be counted exactly. The second has two digits and a 600-cycle window, which makes overflow reachable in a few hundred edges. It checks the wrap to 00 and to 05, and that the flag clears on the following result.

// File: rtl/fc_pkg.sv
package fc_pkg;

    localparam int BCD_W = 4;
    localparam logic [BCD_W-1:0] BCD_MAX = 4'd9;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef enum logic [1:0] {
        PH_GATE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_CLEAR  = 2'd2
    } phase_e;

    typedef struct packed {
        logic gate;
        logic strobe;
        logic clear;
    } seq_ctl_t;

    function automatic bcd_t bcd_next(bcd_t d);
        return (d == BCD_MAX) ? '0 : bcd_t'(d + 4'd1);
    endfunction

    function automatic logic bcd_wraps(bcd_t d, logic inc);
        return inc && (d == BCD_MAX);
    endfunction

endpackage

// File: rtl/fc_input_sync.sv
module fc_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    // sh[DEPTH-1] is the last synchronized level, sh[DEPTH] the level one cycle earlier
    logic [DEPTH:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[DEPTH-1:0], sig_i};
    end

    assign rise_o = sh[DEPTH-1] & ~sh[DEPTH];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R9

endmodule

// File: rtl/fc_gate_seq.sv
module fc_gate_seq
    import fc_pkg::*;
#(
    parameter int GATE_CYCLES = 20000
) (
    input  logic     clk,
    input  logic     rst,
    output seq_ctl_t ctl_o
);
    localparam int TW = (GATE_CYCLES < 2) ? 1 : $clog2(GATE_CYCLES);
    localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

    phase_e        phase_q;
    logic [TW-1:0] timer_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_GATE;
            timer_q <= '0;
        end else begin
            unique case (phase_q)
                PH_GATE: begin
                    if (timer_q == LAST) begin
                        phase_q <= PH_STROBE;
                        timer_q <= '0;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                PH_STROBE: phase_q <= PH_CLEAR;
                default:   phase_q <= PH_GATE;
            endcase
        end
    end

    always_comb begin
        ctl_o.gate   = (phase_q == PH_GATE);
        ctl_o.strobe = (phase_q == PH_STROBE);
        ctl_o.clear  = (phase_q == PH_CLEAR);
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $countones(ctl_o) == 1); // R4
    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.gate && timer_q != LAST) |=> ctl_o.gate); // R4
    AST_STROBE_THEN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ctl_o.strobe |=> ctl_o.clear); // R7
    AST_CLEAR_THEN_GATE: assert property (@(posedge clk) disable iff (rst)
        ctl_o.clear |=> (ctl_o.gate && timer_q == '0)); // R4

endmodule

// File: rtl/fc_decade.sv
module fc_decade
    import fc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output bcd_t digit_o,
    output logic carry_o
);
    always_ff @(posedge clk) begin
        if (rst || clr)  digit_o <= '0;
        else if (inc)    digit_o <= bcd_next(digit_o);
    end

    assign carry_o = bcd_wraps(digit_o, inc);

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        digit_o <= BCD_MAX); // R3
    AST_DIGIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(digit_o)); // R3
    AST_DIGIT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (carry_o && !clr) |=> (digit_o == '0)); // R3

endmodule

// File: rtl/freq_counter_top.sv
module freq_counter_top
    import fc_pkg::*;
#(
    parameter int GATE_CYCLES = 20000,
    parameter int NUM_DIGITS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sig_i,
    output logic [BCD_W*NUM_DIGITS-1:0] digits_o,
    output logic                        ovf_o,
    output logic                        valid_o
);
    localparam int CNT_W = BCD_W * NUM_DIGITS;

    logic            rise;
    seq_ctl_t        ctl;
    logic            count_en;
    logic            pre_q;
    logic            ovf_q;
    logic [NUM_DIGITS:0] inc;
    logic [CNT_W-1:0]    cnt_flat;

    fc_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (sig_i),
        .rise_o (rise)
    );

    fc_gate_seq #(.GATE_CYCLES(GATE_CYCLES)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .ctl_o (ctl)
    );

    // divide-by-two ahead of the decades
    assign count_en = rise & ctl.gate;
    assign inc[0]   = count_en & pre_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) pre_q <= 1'b0;
        else if (count_en)    pre_q <= ~pre_q;
    end

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dec
        bcd_t dig;
        fc_decade u_dec (
            .clk     (clk),
            .rst     (rst),
            .clr     (ctl.clear),
            .inc     (inc[k]),
            .digit_o (dig),
            .carry_o (inc[k+1])
        );
        assign cnt_flat[BCD_W*k +: BCD_W] = dig;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clear)     ovf_q <= 1'b0;
        else if (inc[NUM_DIGITS]) ovf_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            digits_o <= '0;
            ovf_o    <= 1'b0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= ctl.strobe;
            if (ctl.strobe) begin
                digits_o <= cnt_flat;
                ovf_o    <= ovf_q;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R5
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !ctl.strobe |=> ($stable(digits_o) && $stable(ovf_o))); // R6
    AST_CLEAN_START: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> (cnt_flat == '0 && !pre_q && !ovf_q)); // R7
    AST_NO_COUNT_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        (!ctl.gate && !ctl.clear) |=> $stable(cnt_flat)); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ctl.clear) |=> ovf_q); // R8

endmodule

// File: tb/test_freq_counter_top.sv
module test_freq_counter_top;
    localparam int CLK_PERIOD = 10;
    localparam int GATE_A = 5200;
    localparam int GATE_B = 600;

    // edges, high-hold cycles, expected decimal result
    localparam int NVEC = 10;
    localparam int VEC [NVEC][3] = '{
        '{0,    1, 0},
        '{1,    1, 0},
        '{2,    1, 1},
        '{19,   1, 9},
        '{20,   1, 10},
        '{3,    6, 1},
        '{199,  1, 99},
        '{2001, 1, 1000},
        '{2579, 1, 1289},
        '{0,    1, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_a = 1'b0;
    logic sig_b = 1'b0;
    logic [15:0] dig_a;
    logic [7:0]  dig_b;
    logic ovf_a, ovf_b, val_a, val_b;
    logic sel = 1'b0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_counter_top #(.GATE_CYCLES(GATE_A), .NUM_DIGITS(4), .SYNC_STAGES(2)) i_freq_counter_top (
        .clk(clk), .rst(rst), .sig_i(sig_a),
        .digits_o(dig_a), .ovf_o(ovf_a), .valid_o(val_a)
    );

    freq_counter_top #(.GATE_CYCLES(GATE_B), .NUM_DIGITS(2), .SYNC_STAGES(2)) i_freq_counter_top_narrow (
        .clk(clk), .rst(rst), .sig_i(sig_b),
        .digits_o(dig_b), .ovf_o(ovf_b), .valid_o(val_b)
    );

    logic [15:0] cur_dig;
    logic cur_ovf, cur_val;
    always_comb begin
        cur_dig = sel ? {8'h00, dig_b} : dig_a;
        cur_ovf = sel ? ovf_b : ovf_a;
        cur_val = sel ? val_b : val_a;
    end

    function automatic logic [15:0] to_bcd(int v, int nd);
        logic [15:0] r = '0;
        for (int k = 0; k < nd; k++) begin
            r[4*k +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!cur_val);
    endtask

    task automatic send_edges(int n, int hi);
        for (int i = 0; i < n; i++) begin
            if (sel) sig_b = 1'b1; else sig_a = 1'b1;
            repeat (hi) @(negedge clk);
            if (sel) sig_b = 1'b0; else sig_a = 1'b0;
            @(negedge clk);
        end
    endtask

    // called at the negedge where valid was seen; ends at the next such negedge
    task automatic measure(int n, int hi, int exp, bit exp_ovf, int nd, string tag);
        logic [15:0] held;
        @(negedge clk);
        check("R5 valid one cycle", {31'd0, cur_val}, 32'd0);
        repeat (7) @(negedge clk);
        held = cur_dig;
        send_edges(n, hi);
        check("R6 hold during window", {16'd0, cur_dig}, {16'd0, held});
        wait_valid();
        check(tag, {16'd0, cur_dig}, {16'd0, to_bcd(exp, nd)});
        check("R8 overflow flag", {31'd0, cur_ovf}, {31'd0, exp_ovf});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 digits in reset", {16'd0, dig_a}, 32'd0);
        check("R1 ovf/valid in reset", {28'd0, ovf_a, val_a, ovf_b, val_b}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 digits after release", {8'd0, dig_b, dig_a[7:0]}, 32'd0);

        // main instance: table walk (R2, R3 carries, R9 long high, R7 zero after large)
        sel = 1'b0;
        wait_valid();
        for (int v = 0; v < NVEC; v++) begin
            measure(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0, 4,
                    (v == 5) ? "R9 held level one edge" :
                    (v == 9) ? "R7 cleared before window" :
                    (v >= 7) ? "R3 carry chain" : "R2 count value");
        end

        // R4: spacing between results
        begin
            int gap = 0;
            do begin @(negedge clk); gap++; end while (!cur_val);
            check("R4 result period", gap, GATE_A + 2);
        end

        // narrow instance: overflow behaviour (R8)
        sel = 1'b1;
        wait_valid();
        measure(199, 1, 99, 1'b0, 2, "R8 full scale");
        measure(200, 1, 0,  1'b1, 2, "R8 wrap to zero");
        measure(210, 1, 5,  1'b1, 2, "R8 wrap modulo");
        measure(4,   1, 2,  1'b0, 2, "R8 flag cleared");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule